// File: doc/BRIEF.md
# Variable-Length Cluster Record Framer

This block gathers cluster records that arrive spread across six parallel byte lanes and packs them into a framed stream of 32-bit words. Each cluster is carried as six characters on every lane at once, so one record is 36 bytes. The lanes need not be aligned. Each lane writes into its own small FIFO, and a cluster is taken only once every lane holds its six characters. The 36 bytes then leave as nine data words.

The number of clusters in an event is not known in advance. A separate one-cycle end-of-event strobe closes the packet. The framer opens a packet with a header word that carries a running event number. It appends each completed cluster, and when the strobe has been seen and no complete cluster is waiting, it ends the packet with a trailer. The trailer holds the cluster count and an error bit. The error bit is set when the strobe arrives while a cluster is only partly delivered; that partial data is thrown away. The output uses a valid/ready handshake, and a control flag marks the header and trailer words.

Top module: `cluster_framer`

## Requirements
- R1: After synchronous active-low reset, `out_vld` is low, and it stays low until a cluster is complete or an end-of-event strobe has been seen.
- R2: Every packet starts with a header word with `out_ctrl`=1 and value {8'hAB, 8'h00, event_number[15:0]}. The event number is 0 for the first packet after reset and goes up by one for each packet.
- R3: A cluster is emitted only after each of the six lanes has delivered six characters (`lane_vld` high with the byte on `lane_byte[8*i+7:8*i]`). Lanes may deliver at different times, with skew of up to five cycles between them.
- R4: A cluster is emitted as nine words with `out_ctrl`=0. Byte j is character (j mod 6) of lane (j div 6), counted in arrival order. Word k carries bytes 4k, 4k+1, 4k+2, 4k+3 in bits [31:24], [23:16], [15:8], [7:0].
- R5: A packet can hold any number of clusters. Every cluster completed before the end-of-event strobe is emitted, in arrival order, before that packet's trailer.
- R6: Every packet ends with a trailer word with `out_ctrl`=1 and value {8'hEE, 7'b0, error, cluster_count[15:0]}. The error flag sits in bit 16.
- R7: An end-of-event strobe with no cluster data produces a header followed directly by a trailer with count 0 and error 0.
- R8: If the strobe arrives while some lane holds a partial cluster, those bytes are discarded and not emitted. The trailer has error=1 and counts only the complete clusters. The next packet starts clean with error=0.
- R9: While `out_vld` is high and `out_rdy` is low, `out_word` and `out_ctrl` hold steady. No word is lost or duplicated under any ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_vld | input | LANES | Per-lane character strobe |
| lane_byte | input | 8*LANES | Per-lane characters, lane i in bits [8i+7:8i] |
| eoe_in | input | 1 | End-of-event pulse, one cycle |
| out_word | output | 32 | Framed output word |
| out_ctrl | output | 1 | High for header and trailer words |
| out_vld | output | 1 | Output word valid |
| out_rdy | input | 1 | Downstream accepts the word |

## Verification
The bench builds the framer with its defaults: six lanes, six characters per lane, and 16-entry lane FIFOs. This depth lets the bench apply five cycles of ascending and descending lane skew while about two clusters wait behind a stalled output, without running into the FIFO limit. With these values the bench can reach packets of zero to four clusters, a partial cluster alone or after complete ones, and random or bursty stalls on the output. It can also catch an early data word in the cycle before the last lane completes.

// File: rtl/clf_pkg.sv
`timescale 1ns/1ps
// clf_pkg: shared constants and types of the cluster framer.
// Assumes a 32-bit output word made of 8-bit characters.
package clf_pkg;
    localparam int CHAR_W = 8;
    localparam int WORD_W = 32;
    localparam int CHARS_PER_WORD = WORD_W / CHAR_W;

    localparam logic [7:0] HEAD_TAG = 8'hAB;
    localparam logic [7:0] TAIL_TAG = 8'hEE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SCAN,
        ST_BODY,
        ST_TAIL
    } clf_state_e;
endpackage

// File: rtl/clf_lane_fifo.sv
`timescale 1ns/1ps
// clf_lane_fifo: per-lane character FIFO. It takes one character per
// cycle and releases POP_N characters at once, which are visible ahead
// of time on peek (oldest character in the top byte).
// Assumes: DEPTH is a power of two and DEPTH >= POP_N. pop is raised only
// when has_set is high. Writes while full are dropped, and the
// environment must avoid them. flush empties the FIFO and drops a
// write made in the same cycle.
module clf_lane_fifo #(
    parameter int DEPTH = 16,
    parameter int POP_N = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [7:0]         wr_byte,
    input  logic               pop,
    output logic               has_set,
    output logic               not_empty,
    output logic [POP_N*8-1:0] peek
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;
    logic          full;
    logic          wr_ok;

    assign full      = (count == CW'(DEPTH));
    assign wr_ok     = wr_en && !full && !flush;
    assign has_set   = (count >= CW'(POP_N));
    assign not_empty = (count != '0);

    // Store an accepted character at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_byte;
        end
    end

    // Advance the pointers and the fill level; reset and flush empty the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + PW'(POP_N);
            end
            count <= count + CW'(wr_ok) - (pop ? CW'(POP_N) : CW'(0));
        end
    end

    // Show the oldest POP_N characters, oldest in the most significant byte.
    for (genvar c = 0; c < POP_N; c++) begin : g_peek
        assign peek[(POP_N-1-c)*8 +: 8] = mem[rd_ptr + PW'(c)];
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |-> !full)
        else $error("lane FIFO written while full");

    // R3
    pop_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> has_set)
        else $error("lane FIFO popped without a full character set");
endmodule

// File: rtl/clf_lane_gather.sv
`timescale 1ns/1ps
// clf_lane_gather: one FIFO per lane. It reports when every lane holds a
// complete share of a cluster and presents the whole cluster as a flat
// byte vector, with byte j = lane*CHARS + char, byte 0 in the top bits.
// Assumes: pop is raised only while cl_rdy is high.
module clf_lane_gather #(
    parameter int LANES = 6,
    parameter int CHARS = 6,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     pop,
    input  logic [LANES-1:0]         lane_vld,
    input  logic [LANES*8-1:0]       lane_byte,
    output logic                     cl_rdy,
    output logic                     any_data,
    output logic [LANES*CHARS*8-1:0] cl_flat
);
    localparam int SLICE_W = CHARS * 8;

    logic [LANES-1:0] lane_has;
    logic [LANES-1:0] lane_ne;

    // One FIFO per lane; lane 0 supplies the top slice of the cluster vector.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        clf_lane_fifo #(
            .DEPTH (DEPTH),
            .POP_N (CHARS)
        ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .wr_en     (lane_vld[i]),
            .wr_byte   (lane_byte[i*8 +: 8]),
            .pop       (pop),
            .has_set   (lane_has[i]),
            .not_empty (lane_ne[i]),
            .peek      (cl_flat[(LANES-1-i)*SLICE_W +: SLICE_W])
        );
    end

    // A cluster is ready only when every lane has delivered its share.
    assign cl_rdy   = &lane_has;
    // Any leftover byte means a partial cluster is held.
    assign any_data = |lane_ne;
endmodule

// File: rtl/clf_pkt_ctrl.sv
`timescale 1ns/1ps
// clf_pkt_ctrl: packet sequencer. It opens a packet with a header, takes
// complete clusters from the lane gather and sends them as data words,
// and closes the packet with a trailer once an end-of-event strobe is
// pending and no complete cluster waits. Partial data at close is flushed
// and flagged in the trailer.
// Assumes: NB is a multiple of four, SEQ_W <= 24, CNT_W <= 16. End-of-event
// is strobed only after the last cluster's bytes have been written.
module clf_pkt_ctrl
    import clf_pkg::*;
#(
    parameter int NB    = 36,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cl_rdy,
    input  logic            any_data,
    input  logic [NB*8-1:0] cl_flat,
    input  logic            eoe_in,
    output logic            pop,
    output logic            flush,
    output logic [31:0]     out_word,
    output logic            out_ctrl,
    output logic            out_vld,
    input  logic            out_rdy
);
    localparam int NW = NB / CHARS_PER_WORD;
    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    clf_state_e       state;
    logic [NB*8-1:0]  clu_buf;
    logic [IW-1:0]    idx_q;
    logic [SEQ_W-1:0] seq_q;
    logic [CNT_W-1:0] clu_cnt;
    logic             err_q;
    logic             eoe_pend;
    logic             close_now;
    logic             hs;
    logic [31:0]      words [NW];

    assign hs        = out_vld && out_rdy;
    assign close_now = (state == ST_SCAN) && !cl_rdy && eoe_pend;
    assign pop       = (state == ST_SCAN) && cl_rdy;
    assign flush     = close_now && any_data;

    // Split the held cluster into words, byte 0 at the top of word 0.
    for (genvar k = 0; k < NW; k++) begin : g_word
        assign words[k] = clu_buf[(NW-1-k)*32 +: 32];
    end

    // Remember an end-of-event strobe until the packet is closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoe_pend <= 1'b0;
        end else begin
            eoe_pend <= (eoe_pend && !close_now) || eoe_in;
        end
    end

    // Packet sequencing: header, clusters, trailer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx_q   <= '0;
            seq_q   <= '0;
            clu_cnt <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cl_rdy || eoe_pend) begin
                        state <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (hs) begin
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (pop) begin
                        idx_q <= '0;
                        state <= ST_BODY;
                    end else if (close_now) begin
                        err_q <= any_data;
                        state <= ST_TAIL;
                    end
                end
                ST_BODY: begin
                    if (hs) begin
                        if (idx_q == IW'(NW - 1)) begin
                            clu_cnt <= clu_cnt + 1'b1;
                            state   <= ST_SCAN;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (hs) begin
                        seq_q   <= seq_q + 1'b1;
                        clu_cnt <= '0;
                        err_q   <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture a complete cluster as it leaves the lane FIFOs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clu_buf <= '0;
        end else if (pop) begin
            clu_buf <= cl_flat;
        end
    end

    // Drive the output word for the current state.
    always_comb begin
        out_word = '0;
        out_ctrl = 1'b0;
        out_vld  = 1'b0;
        case (state)
            ST_HEAD: begin
                out_word = {HEAD_TAG, 24'(seq_q)};
                out_ctrl = 1'b1;
                out_vld  = 1'b1;
            end
            ST_BODY: begin
                out_word = words[idx_q];
                out_vld  = 1'b1;
            end
            ST_TAIL: begin
                out_word = {TAIL_TAG, 7'b0, err_q, 16'(clu_cnt)};
                out_ctrl = 1'b1;
                out_vld  = 1'b1;
            end
            default: ;
        endcase
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_word) && $stable(out_ctrl)))
        else $error("output changed while stalled");

    // R6
    tail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && hs) |=> (clu_cnt == '0 && !err_q))
        else $error("count or error carried into next packet");

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && hs) |=> (seq_q == $past(seq_q) + 1'b1))
        else $error("event number did not advance by one");
endmodule

// File: rtl/cluster_framer.sv
`timescale 1ns/1ps
// cluster_framer: top of the variable-length cluster framer. It joins the
// per-lane gather stage with the packet sequencer.
// Assumes: lanes carry decoded characters, the end-of-event strobe follows
// the last character of the event, and the next event's characters start
// only after the trailer of the previous packet has been accepted.
module cluster_framer #(
    parameter int LANES      = 6,
    parameter int CHARS      = 6,
    parameter int FIFO_DEPTH = 16,
    parameter int SEQ_W      = 16,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   lane_vld,
    input  logic [LANES*8-1:0] lane_byte,
    input  logic               eoe_in,
    output logic [31:0]        out_word,
    output logic               out_ctrl,
    output logic               out_vld,
    input  logic               out_rdy
);
    localparam int NB = LANES * CHARS;

    logic            pop;
    logic            flush;
    logic            cl_rdy;
    logic            any_data;
    logic [NB*8-1:0] cl_flat;

    clf_lane_gather #(
        .LANES (LANES),
        .CHARS (CHARS),
        .DEPTH (FIFO_DEPTH)
    ) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .pop       (pop),
        .lane_vld  (lane_vld),
        .lane_byte (lane_byte),
        .cl_rdy    (cl_rdy),
        .any_data  (any_data),
        .cl_flat   (cl_flat)
    );

    clf_pkt_ctrl #(
        .NB    (NB),
        .SEQ_W (SEQ_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cl_rdy   (cl_rdy),
        .any_data (any_data),
        .cl_flat  (cl_flat),
        .eoe_in   (eoe_in),
        .pop      (pop),
        .flush    (flush),
        .out_word (out_word),
        .out_ctrl (out_ctrl),
        .out_vld  (out_vld),
        .out_rdy  (out_rdy)
    );
endmodule

// File: tb/cluster_framer_tb.sv
`timescale 1ns/1ps
module cluster_framer_tb;
    localparam int LANES = 6;
    localparam int CHARS = 6;
    localparam int NB    = LANES * CHARS;
    localparam int NW    = NB / 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [LANES-1:0]   lane_vld = '0;
    logic [LANES*8-1:0] lane_byte = '0;
    logic               eoe_in = 1'b0;
    logic [31:0]        out_word;
    logic               out_ctrl;
    logic               out_vld;
    logic               out_rdy = 1'b1;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    int seq_exp = 0;
    int clu_id = 0;
    bit done = 1'b0;

    logic [32:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    cluster_framer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_vld  (lane_vld),
        .lane_byte (lane_byte),
        .eoe_in    (eoe_in),
        .out_word  (out_word),
        .out_ctrl  (out_ctrl),
        .out_vld   (out_vld),
        .out_rdy   (out_rdy)
    );

    task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard pushes
    task automatic push(input logic [32:0] w, input string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    task automatic open_event();
        push({1'b1, 8'hAB, 8'h00, 16'(seq_exp)}, "R2 header");
        seq_exp++;
    endtask

    task automatic close_event(input bit err, input int cnt, input string tag);
        push({1'b1, 8'hEE, 7'b0, err, 16'(cnt)}, tag);
        @(posedge clk); #1;
        eoe_in = 1'b1;
        @(posedge clk); #1;
        eoe_in = 1'b0;
        wait (exp_q.size() == 0);
        repeat (3) @(posedge clk);
    endtask

    // skew_mode: 0 none, 1 ascending (lane i delayed i), 2 descending
    task automatic send_cluster(input int skew_mode, input int gap, input bit chk_early);
        logic [7:0] b [NB];
        int skew [LANES];
        for (int j = 0; j < NB; j++) b[j] = 8'(clu_id * 37 + j * 11 + 5);
        for (int k = 0; k < NW; k++)
            push({1'b0, b[4*k], b[4*k+1], b[4*k+2], b[4*k+3]}, "R4 data word");
        clu_id++;
        for (int i = 0; i < LANES; i++)
            skew[i] = (skew_mode == 1) ? i : (skew_mode == 2) ? (LANES - 1 - i) : 0;
        for (int t = 0; t < CHARS + LANES - 1; t++) begin
            @(posedge clk); #1;
            for (int i = 0; i < LANES; i++) begin
                int c;
                c = t - skew[i];
                lane_vld[i] = (c >= 0 && c < CHARS);
                lane_byte[i*8 +: 8] = (c >= 0 && c < CHARS) ? b[i*CHARS + c] : 8'h00;
            end
            if (chk_early && t == CHARS + LANES - 2) begin
                @(negedge clk);
                // R3: last lane not yet complete, so no data word may be offered
                check(!(out_vld && !out_ctrl), "R3 no data before last lane",
                      {out_ctrl, out_word}, {1'b1, 32'h0});
            end
        end
        @(posedge clk); #1;
        lane_vld = '0;
        repeat (gap) @(posedge clk);
    endtask

    // Partial cluster: lanes 0..2 deliver n characters only
    task automatic send_partial(input int n);
        for (int t = 0; t < n; t++) begin
            @(posedge clk); #1;
            lane_vld = 6'b000111;
            lane_byte = {LANES{8'(8'hC0 + t)}};
        end
        @(posedge clk); #1;
        lane_vld = '0;
    endtask

    // Ready pattern generator
    initial begin
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0: out_rdy = 1'b1;
                1: out_rdy = ($urandom_range(0, 3) != 0);
                default: out_rdy = ($urandom_range(0, 7) > 5);
            endcase
        end
    end

    // Monitor: compare each accepted word with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && out_vld && out_rdy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected word", {out_ctrl, out_word}, 33'h0);
            end else begin
                logic [32:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                check({out_ctrl, out_word} === e, tg, {out_ctrl, out_word}, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_vld == 1'b0, "R1 idle after reset", {32'h0, out_vld}, 33'h0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(out_vld == 1'b0, "R1 idle with no input", {32'h0, out_vld}, 33'h0);

        // One aligned cluster
        open_event();
        send_cluster(0, 0, 1'b0);
        close_event(1'b0, 1, "R6 trailer one cluster");

        // Three clusters with ascending skew, early-data probe on the first
        open_event();
        send_cluster(1, 0, 1'b1);
        send_cluster(1, 0, 1'b0);
        send_cluster(1, 0, 1'b0);
        close_event(1'b0, 3, "R5 trailer three clusters");

        // Empty event
        open_event();
        close_event(1'b0, 0, "R7 empty trailer");

        // Partial only
        open_event();
        send_partial(4);
        close_event(1'b1, 0, "R8 partial only trailer");

        // Two clusters then a partial
        open_event();
        send_cluster(2, 0, 1'b0);
        send_cluster(0, 0, 1'b0);
        send_partial(2);
        close_event(1'b1, 2, "R8 partial after clusters trailer");

        // Clean event after the error
        open_event();
        send_cluster(0, 0, 1'b0);
        close_event(1'b0, 1, "R8 clean after error trailer");

        // Random stalls with descending skew
        rdy_mode = 1;
        open_event();
        for (int n = 0; n < 4; n++) send_cluster(2, 12, 1'b0);
        close_event(1'b0, 4, "R9 random stall trailer");

        // Heavy stalls
        rdy_mode = 2;
        open_event();
        send_cluster(1, 40, 1'b0);
        send_cluster(0, 40, 1'b0);
        close_event(1'b0, 2, "R9 heavy stall trailer");

        rdy_mode = 0;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(out_vld == 1'b0 && exp_q.size() == 0, "R5 nothing left over",
              {32'(exp_q.size()), out_vld}, 33'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule